// File: doc/BRIEF.md
# Real-Time Counter and Watchdog with Shared Prescaler

This block holds an 8-bit real-time counter and an 8-bit watchdog counter that share a single 8-bit programmable prescaler. A 6-bit mode register controls it. The mode register picks the counter's source, which is either the instruction-cycle strobe or a transition on an external pin that has already been synchronized. It also picks which pin edge counts, which of the two counters owns the prescaler, and a 3-bit ratio code. The counter that does not own the prescaler is clocked directly by its own tick.

Software can read the counter value at any time and can overwrite it through a simple write port. The watchdog advances on a free-running tick input. The clear-watchdog command and the sleep command both bring its count back to zero. When the watchdog is enabled and its count overflows, the block raises a one-cycle reset request.

Top module: `rtc_wdt_timer`

## Requirements
- R1: On reset the mode register holds binary 11_1111, so the counter source is the pin, it counts falling edges, and the prescaler is given to the watchdog at ratio code 7. On reset the counter value and the reset request are both 0.
- R2: Mode bit 5 selects the counter source: 0 selects the instruction-cycle strobe and 1 selects pin transitions. The source that is not selected has no effect on the counter.
- R3: Mode bit 4 selects the pin polarity: 0 counts low-to-high transitions and 1 counts high-to-low transitions. Each qualifying transition produces exactly one count event, in the clock cycle where the new pin level is first seen.
- R4: Mode bit 3 assigns the prescaler: 0 gives it to the counter and 1 gives it to the watchdog. The counter that does not own the prescaler advances once per source event.
- R5: When the counter owns the prescaler, ratio code k (mode bits 2:0) gives one counter increment per 2^(k+1) source events, from 1:2 up to 1:256.
- R6: When the watchdog owns the prescaler, ratio code k gives one watchdog increment per 2^k ticks, from 1:1 up to 1:128.
- R7: A counter write loads the written value and clears the prescaler. A write takes priority over a count event in the same cycle.
- R8: The counter wraps from FFh to 00h.
- R9: The clear-watchdog command and the sleep command each set the watchdog count to 0. The clear-watchdog command also clears the prescaler, but only while the watchdog owns it.
- R10: When the watchdog is enabled, the increment that takes its count past FFh raises the reset request for exactly one cycle. While the watchdog is disabled, its count is held at 0 and no request is raised.
- R11: When a clear or sleep command arrives in the same cycle as the overflowing increment, the command wins and no reset request is raised.
- R12: The mode register loads the mode data input only in a cycle where the load strobe is high. At all other times it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_tick | input | 1 | Instruction-cycle strobe, one cycle per instruction |
| ext_pin | input | 1 | Synchronized external count pin |
| wdt_tick | input | 1 | Free-running watchdog tick |
| wdt_en | input | 1 | Watchdog enable |
| mode_load | input | 1 | Load strobe for the mode register |
| mode_wdata | input | 6 | Mode data: bit 5 source, bit 4 polarity, bit 3 assignment, bits 2:0 ratio |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write data |
| clr_wdt | input | 1 | Clear-watchdog command |
| sleep_cmd | input | 1 | Sleep command |
| cnt_value | output | 8 | Current counter value |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
Two pairs of events can collide in one cycle. The first pair is a counter write and a counter count event. The bench holds the instruction strobe high while it writes, and then checks that the counter shows exactly the written value, followed by that value plus one on the next strobe. The second pair is a clear-watchdog command and the tick that would overflow the watchdog. The bench first brings the watchdog to FFh, then raises both inputs together. It judges the result by the absence of a reset request, and by the fact that a full 256 further ticks are then needed to reach the next request.

// File: rtl/tmr_pkg.sv
// Package: shared mode-register layout and reset value for the
// counter/watchdog block. Bit positions are decoded by the top level.
package tmr_pkg;
    localparam int TMR_RATIO_W = 3;
    localparam int TMR_MODE_W  = 6;

    // Mode register layout, msb first: source, polarity, owner, ratio.
    typedef struct packed {
        logic                   src_ext;   // 1: pin transitions, 0: instruction strobe
        logic                   edge_fall; // 1: high-to-low, 0: low-to-high
        logic                   psc_wdt;   // 1: prescaler owned by watchdog
        logic [TMR_RATIO_W-1:0] ratio;     // prescale ratio code
    } tmr_mode_t;

    localparam logic [TMR_MODE_W-1:0] TMR_MODE_RESET = 6'b11_1111;
endpackage

// File: rtl/tmr_edge_det.sv
// Edge detector: compares the synchronized pin with a registered copy
// and emits one tick per transition of the selected polarity.
// Assumes the pin is already synchronous to clk.
module tmr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic tick_o
);
    logic prev_q;
    logic rise;
    logic fall;

    // Hold the previous pin sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_i;
    end

    // Decode a transition of the chosen polarity.
    always_comb begin
        rise   = pin_i & ~prev_q;
        fall   = ~pin_i & prev_q;
        tick_o = fall_sel_i ? fall : rise;
    end

    // A transition yields a single tick unless the polarity was switched.
    assert_single_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (!tick_o || (fall_sel_i != $past(fall_sel_i))));
endmodule

// File: rtl/tmr_prescaler.sv
// Prescaler: counts input ticks and passes one tick out per 2^shift_i
// input ticks (shift 0 passes every tick). A clear zeroes the count and
// suppresses the output in that cycle.
module tmr_prescaler #(
    parameter int PSC_W = 8,
    localparam int SHW  = $clog2(PSC_W + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic           clear_i,
    input  logic [SHW-1:0] shift_i,
    output logic           tick_o
);
    logic [PSC_W-1:0] count_q;
    logic [PSC_W-1:0] mask;
    logic             full;

    // Mask selects the low shift_i bits of the count.
    for (genvar g = 0; g < PSC_W; g++) begin : g_mask
        assign mask[g] = (shift_i > SHW'(g));
    end

    // Tap fires when all selected count bits are one.
    always_comb begin
        full   = &(count_q | ~mask);
        tick_o = tick_i & full & ~clear_i;
    end

    // Advance or clear the prescale count.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (clear_i) count_q <= '0;
        else if (tick_i)  count_q <= count_q + 1'b1;
    end

    assert_clear_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (count_q == '0));
    assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !tick_i) |=> $stable(count_q));
endmodule

// File: rtl/rtc_counter.sv
// Real-time counter: loadable up-counter that wraps at full scale.
// A write takes priority over an increment in the same cycle.
module rtc_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             we_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] value_o
);
    // Load, increment or hold the counter.
    always_ff @(posedge clk) begin
        if (!rst_n)     value_o <= '0;
        else if (we_i)  value_o <= wdata_i;
        else if (inc_i) value_o <= value_o + 1'b1;
    end

    assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (value_o == $past(wdata_i)));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i && !inc_i) |=> $stable(value_o));
endmodule

// File: rtl/wdt_counter.sv
// Watchdog counter: counts prescaled ticks while enabled, is zeroed by
// clear or sleep, and emits a one-cycle request on overflow.
// Held at zero while disabled.
module wdt_counter #(
    parameter int WDT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic inc_i,
    input  logic clear_i,
    output logic rst_req_o
);
    localparam logic [WDT_W-1:0] WDT_MAX = '1;
    logic [WDT_W-1:0] count_q;

    // Count, clear and flag overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            rst_req_o <= 1'b0;
        end else begin
            rst_req_o <= 1'b0;
            if (clear_i || !en_i) begin
                count_q <= '0;
            end else if (inc_i) begin
                count_q <= count_q + 1'b1;
                if (count_q == WDT_MAX) rst_req_o <= 1'b1;
            end
        end
    end

    assert_req_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);
    assert_req_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> $past(en_i));
    assert_clear_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (count_q == '0 && !rst_req_o));
endmodule

// File: rtl/rtc_wdt_timer.sv
// Top: mode register, source and polarity selection, and routing of the
// shared prescaler between the real-time counter and the watchdog.
// Assumes ext_pin is synchronous and all strobes are single-cycle.
module rtc_wdt_timer #(
    parameter int CNT_W = 8,
    parameter int WDT_W = 8,
    parameter int PSC_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       instr_tick,
    input  logic                       ext_pin,
    input  logic                       wdt_tick,
    input  logic                       wdt_en,
    input  logic                       mode_load,
    input  logic [tmr_pkg::TMR_MODE_W-1:0] mode_wdata,
    input  logic                       cnt_we,
    input  logic [CNT_W-1:0]           cnt_wdata,
    input  logic                       clr_wdt,
    input  logic                       sleep_cmd,
    output logic [CNT_W-1:0]           cnt_value,
    output logic                       wdt_rst_req
);
    import tmr_pkg::*;
    localparam int SHW = $clog2(PSC_W + 1);

    tmr_mode_t      mode_q;
    logic           pin_tick;
    logic           cnt_src;
    logic           psc_in;
    logic           psc_out;
    logic           psc_clear;
    logic [SHW-1:0] psc_shift;
    logic           cnt_inc;
    logic           wdt_inc;
    logic           wdt_clear;

    // Mode register, loaded on the dedicated strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= tmr_mode_t'(TMR_MODE_RESET);
        else if (mode_load) mode_q <= tmr_mode_t'(mode_wdata);
    end

    tmr_edge_det u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (ext_pin),
        .fall_sel_i (mode_q.edge_fall),
        .tick_o     (pin_tick)
    );

    // Route sources through or around the prescaler.
    always_comb begin
        cnt_src   = mode_q.src_ext ? pin_tick : instr_tick;
        psc_in    = mode_q.psc_wdt ? wdt_tick : cnt_src;
        psc_shift = mode_q.psc_wdt ? SHW'(mode_q.ratio) : SHW'(mode_q.ratio) + 1'b1;
        psc_clear = cnt_we | (clr_wdt & mode_q.psc_wdt);
        cnt_inc   = mode_q.psc_wdt ? cnt_src : psc_out;
        wdt_inc   = mode_q.psc_wdt ? psc_out : wdt_tick;
        wdt_clear = clr_wdt | sleep_cmd;
    end

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (psc_in),
        .clear_i (psc_clear),
        .shift_i (psc_shift),
        .tick_o  (psc_out)
    );

    rtc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (cnt_inc),
        .we_i    (cnt_we),
        .wdata_i (cnt_wdata),
        .value_o (cnt_value)
    );

    wdt_counter #(.WDT_W(WDT_W)) u_wdt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (wdt_en),
        .inc_i     (wdt_inc),
        .clear_i   (wdt_clear),
        .rst_req_o (wdt_rst_req)
    );

    assert_mode_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mode_load |=> (mode_q == $past(mode_wdata)));
    assert_mode_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_load |=> $stable(mode_q));
endmodule

// File: tb/tb_rtc_wdt_timer.sv
module tb_rtc_wdt_timer;
    localparam time CLK_P = 8ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_tick = 1'b0;
    logic       ext_pin = 1'b0;
    logic       wdt_tick = 1'b0;
    logic       wdt_en = 1'b1;
    logic       mode_load = 1'b0;
    logic [5:0] mode_wdata = '0;
    logic       cnt_we = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic       clr_wdt = 1'b0;
    logic       sleep_cmd = 1'b0;
    logic [7:0] cnt_value;
    logic       wdt_rst_req;

    int n_chk = 0;
    int n_fail = 0;
    int req_seen = 0;

    always #(CLK_P/2) clk = ~clk;

    rtc_wdt_timer dut (
        .clk(clk), .rst_n(rst_n), .instr_tick(instr_tick), .ext_pin(ext_pin),
        .wdt_tick(wdt_tick), .wdt_en(wdt_en), .mode_load(mode_load),
        .mode_wdata(mode_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .clr_wdt(clr_wdt), .sleep_cmd(sleep_cmd), .cnt_value(cnt_value),
        .wdt_rst_req(wdt_rst_req)
    );

    // Vector layout: {mode[5:0], events[15:0], expected counter[7:0]}
    localparam logic [29:0] VEC [9] = '{
        {6'h08, 16'd10,  8'd10},  // R4 non-owner 1:1, R2 strobe source
        {6'h00, 16'd10,  8'd5},   // R5 code 0 -> 1:2
        {6'h02, 16'd20,  8'd2},   // R5 code 2 -> 1:8
        {6'h07, 16'd600, 8'd2},   // R5 code 7 -> 1:256
        {6'h20, 16'd9,   8'd4},   // R3 rising, R5 1:2
        {6'h30, 16'd9,   8'd4},   // R3 falling, R5 1:2
        {6'h28, 16'd7,   8'd7},   // R2 pin source, direct
        {6'h05, 16'd130, 8'd2},   // R5 code 5 -> 1:64
        {6'h08, 16'd300, 8'h2C}   // R8 wrap: 300 mod 256
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic instr_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            instr_tick = 1'b1;
            @(negedge clk);
        end
        instr_tick = 1'b0;
    endtask

    task automatic pin_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_pin = 1'b1;
            @(negedge clk);
            ext_pin = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic wdt_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            wdt_tick = 1'b1;
            @(negedge clk);
            if (wdt_rst_req) req_seen++;
        end
        wdt_tick = 1'b0;
    endtask

    task automatic load_mode(input logic [5:0] m);
        mode_wdata = m;
        mode_load  = 1'b1;
        @(negedge clk);
        mode_load  = 1'b0;
    endtask

    task automatic write_cnt(input logic [7:0] v);
        cnt_wdata = v;
        cnt_we    = 1'b1;
        @(negedge clk);
        cnt_we    = 1'b0;
    endtask

    task automatic pulse_clr();
        clr_wdt = 1'b1;
        @(negedge clk);
        clr_wdt = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 300000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 counter after reset", cnt_value, 0);
        check("R1 request after reset", wdt_rst_req, 0);
        instr_pulses(3);
        check("R1 strobe ignored in pin mode (R2)", cnt_value, 0);
        ext_pin = 1'b1;
        @(negedge clk);
        check("R1 rising edge ignored", cnt_value, 0);
        ext_pin = 1'b0;
        @(negedge clk);
        check("R1 falling edge counts", cnt_value, 1);
        req_seen = 0;
        wdt_pulses(32767);
        check("R1 watchdog 1:128 before overflow", req_seen, 0);
        wdt_pulses(1);
        check("R1 watchdog 1:128 overflow", req_seen, 1);

        // Table walk
        wdt_en = 1'b0;
        for (int i = 0; i < 9; i++) begin
            load_mode(VEC[i][29:24]);
            write_cnt(8'h00);
            if (VEC[i][29]) pin_pulses(int'(VEC[i][23:8]));
            else            instr_pulses(int'(VEC[i][23:8]));
            check($sformatf("R5 vector %0d", i), cnt_value, int'(VEC[i][7:0]));
        end

        // R2: unselected sources ignored
        load_mode(6'h28);
        write_cnt(8'h10);
        instr_pulses(5);
        check("R2 strobe ignored in pin mode", cnt_value, 8'h10);
        load_mode(6'h08);
        pin_pulses(4);
        check("R2 pin ignored in strobe mode", cnt_value, 8'h10);

        // R3: count in the cycle the new level appears
        load_mode(6'h28);
        write_cnt(8'h00);
        ext_pin = 1'b1;
        @(negedge clk);
        check("R3 rise counted immediately", cnt_value, 1);
        ext_pin = 1'b0;
        @(negedge clk);
        check("R3 fall ignored in rising mode", cnt_value, 1);

        // R12: data without strobe is ignored
        load_mode(6'h08);
        write_cnt(8'h00);
        mode_wdata = 6'h00;
        @(negedge clk);
        instr_pulses(4);
        check("R12 mode held without load", cnt_value, 4);

        // R7: write and tick collide
        instr_tick = 1'b1;
        cnt_wdata  = 8'h40;
        cnt_we     = 1'b1;
        @(negedge clk);
        cnt_we = 1'b0;
        check("R7 write wins over tick", cnt_value, 8'h40);
        @(negedge clk);
        instr_tick = 1'b0;
        check("R7 tick after write", cnt_value, 8'h41);

        // R7: write clears prescaler
        load_mode(6'h00);
        write_cnt(8'h00);
        instr_pulses(1);
        write_cnt(8'h05);
        instr_pulses(1);
        check("R7 prescaler cleared by write", cnt_value, 5);
        instr_pulses(1);
        check("R7 increment after two events", cnt_value, 6);

        // R9: clear-watchdog leaves counter-owned prescaler alone
        write_cnt(8'h00);
        instr_pulses(1);
        pulse_clr();
        instr_pulses(1);
        check("R9 clear does not touch counter prescaler", cnt_value, 1);

        // R10: disabled watchdog
        load_mode(6'h08);
        wdt_en = 1'b0;
        req_seen = 0;
        wdt_pulses(300);
        check("R10 no request while disabled", req_seen, 0);
        wdt_en = 1'b1;
        wdt_pulses(255);
        check("R10 count held at zero while disabled", req_seen, 0);
        wdt_pulses(1);
        check("R10 request on overflow", req_seen, 1);
        @(negedge clk);
        check("R10 request lasts one cycle", wdt_rst_req, 0);

        // R11: clear collides with the overflowing tick
        pulse_clr();
        req_seen = 0;
        wdt_pulses(255);
        clr_wdt  = 1'b1;
        wdt_tick = 1'b1;
        @(negedge clk);
        clr_wdt  = 1'b0;
        wdt_tick = 1'b0;
        check("R11 clear wins over overflow", wdt_rst_req, 0);
        wdt_pulses(255);
        check("R11 count restarted", req_seen, 0);
        wdt_pulses(1);
        check("R11 next overflow after full period", req_seen, 1);

        // R9: sleep zeroes count
        req_seen = 0;
        wdt_pulses(100);
        sleep_cmd = 1'b1;
        @(negedge clk);
        sleep_cmd = 1'b0;
        wdt_pulses(255);
        check("R9 sleep zeroes watchdog", req_seen, 0);
        wdt_pulses(1);
        check("R9 overflow after sleep", req_seen, 1);

        // R6: watchdog 1:2, clear zeroes owned prescaler
        load_mode(6'h09);
        wdt_pulses(1);
        pulse_clr();
        req_seen = 0;
        wdt_pulses(511);
        check("R6 watchdog 1:2 before overflow", req_seen, 0);
        wdt_pulses(1);
        check("R6 watchdog 1:2 overflow", req_seen, 1);

        // R4: watchdog direct when counter owns prescaler
        load_mode(6'h07);
        pulse_clr();
        req_seen = 0;
        wdt_pulses(255);
        check("R4 watchdog direct before overflow", req_seen, 0);
        wdt_pulses(1);
        check("R4 watchdog direct overflow", req_seen, 1);

        finish_run();
    end
endmodule